// File: doc/BRIEF.md
# Byte-Wise Code Memory Programming Controller

This block runs the parallel programming mode of an on-chip code memory. An external programmer sets an address, a data byte and an operation select. It then raises the high-voltage-valid qualifier and gives one pulse on the program strobe. The controller starts a self-timed byte write into a behavioural memory array. It drops the ready output for the whole write time. While that write is in progress, it serves data polling on read-back of the byte being written.

The same strobe can also carry a lock-bit program command. That command is not stored locally: it is passed on as a one-cycle request to the lock protection unit. That unit returns two qualifiers, one that blocks code writes and one that blocks verify reads, and the controller honours both. Holding both signature select lines low turns the read path into a fixed identification table.

A strobe that cannot be honoured leaves memory and timing untouched. It sets a sticky error flag.

Top module: `byte_prog_ctrl`

## Requirements
- R1: After reset, ready is 1, err_flag is 0, lock_req is 0 and rdata is 00h.
- R2: A code write starts when a rising edge of prog_strobe is sampled with op = 01 and hv_ok = 1, while ready is 1 and prog_dis is 0. wdata is stored at addr, and ready is 0 from the next cycle on.
- R3: Ready stays 0 for exactly WRITE_CYCLES clock cycles after an accepted command, then returns to 1.
- R4: Every read is registered, so rdata shows the result one cycle after addr is sampled. While a code write is in progress, reading its address returns the stored byte with bit 7 inverted and bits 6:0 true.
- R5: Once the write ends, the written address reads back its true data. Other addresses read normally during a write.
- R6: A strobe rising edge is rejected when ready is 0, when hv_ok is 0, when op is 00 or 11, or when op is 01 while prog_dis is 1. A rejected edge writes nothing, does not start busy, and sets err_flag on the next cycle. err_flag stays set until reset.
- R7: A lock command (op = 10) is accepted even while prog_dis is 1. It pulses lock_req for one cycle with lock_id = addr[1:0], holds ready low for the write time, leaves memory unchanged and enables no polling.
- R8: With verify_dis = 1 and the signature select not active, rdata is 00h.
- R9: With sig_sel_n = 00, rdata is 1Eh at address 30h, 87h at 31h, 01h at 32h and 00h at any other address, whatever verify_dis is.
- R10: Only a rising edge of prog_strobe counts. A strobe held high starts at most one command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Code memory address for write, read or lock select |
| wdata | input | 8 | Byte to program |
| op | input | 2 | 00 read, 01 code write, 10 lock program, 11 reserved |
| sig_sel_n | input | 2 | Both low selects the signature table |
| hv_ok | input | 1 | High-voltage enable is at its valid level |
| prog_strobe | input | 1 | Program strobe, acts on its rising edge |
| prog_dis | input | 1 | Lock unit blocks code writes |
| verify_dis | input | 1 | Lock unit blocks verify reads |
| rdata | output | 8 | Registered read data |
| ready | output | 1 | 1 when idle, 0 while a write runs |
| err_flag | output | 1 | Sticky flag for rejected strobes |
| lock_req | output | 1 | One-cycle lock program request |
| lock_id | output | 2 | Lock bit selected, held after the request |

## Verification
An edge that samples a strobe rising edge affects the outputs one cycle later. After that edge, ready is 0, err_flag or lock_req is updated, and ready rises again WRITE_CYCLES edges after acceptance. rdata always reflects the address and the array contents as seen at the previous edge. This includes the polling inversion, which ends on the same edge that ends busy. The bench drives inputs just after each rising edge and keeps a behavioural model that advances on that same edge. It compares every output at the falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  typedef enum logic [1:0] {
    OP_READ = 2'b00,
    OP_CODE = 2'b01,
    OP_LOCK = 2'b10,
    OP_RSVD = 2'b11
  } prog_op_e;

  localparam logic [7:0] SIG_ADDR_BASE = 8'h30;

  // identification bytes, indexed from the base address
  function automatic logic [7:0] sig_byte(input logic [1:0] idx);
    logic [7:0] val;
    case (idx)
      2'd0:    val = 8'h1E;
      2'd1:    val = 8'h87;
      2'd2:    val = 8'h01;
      default: val = 8'h00;
    endcase
    return val;
  endfunction

endpackage

// File: rtl/bpc_cmd_decode.sv
module bpc_cmd_decode
  import bpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic       hv_ok,
  input  prog_op_e   op,
  input  logic       prog_dis,
  input  logic       busy,
  output logic       start_code,
  output logic       start_lock,
  output logic       err_flag
);

  logic strobe_q, strobe_d;
  logic err_q, err_d;
  logic rise, op_ok, accept;

  always_comb begin
    rise       = strobe & ~strobe_q;
    op_ok      = ((op == OP_CODE) & ~prog_dis) | (op == OP_LOCK);
    accept     = rise & hv_ok & ~busy & op_ok;
    start_code = accept & (op == OP_CODE);
    start_lock = accept & (op == OP_LOCK);
    strobe_d   = strobe;
    err_d      = err_q | (rise & ~accept);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
      err_q    <= err_d;
    end
  end

  assign err_flag = err_q;

  // R6
  strobe_busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !strobe_q && busy) |=> err_flag);

  // R10
  held_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q && strobe) |-> !(start_code || start_lock));

endmodule

// File: rtl/bpc_write_timer.sv
module bpc_write_timer #(
  parameter int WRITE_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = start | busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> !busy_q);

endmodule

// File: rtl/bpc_read_path.sv
module bpc_read_path
  import bpc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        sig_sel_n,
  input  logic              verify_dis,
  input  logic              poll_hit,
  input  logic [7:0]        mem_word,
  output logic [7:0]        rdata
);

  localparam logic [ADDR_W-1:0] SIG_LO = ADDR_W'(SIG_ADDR_BASE);

  logic [7:0]        rdata_q, rdata_d;
  logic [ADDR_W-1:0] sig_off;
  logic              sig_mode;

  always_comb begin
    sig_mode = (sig_sel_n == 2'b00);
    sig_off  = addr - SIG_LO;
    if (sig_mode) begin
      rdata_d = (sig_off < ADDR_W'(3)) ? sig_byte(sig_off[1:0]) : 8'h00;
    end else if (verify_dis) begin
      rdata_d = 8'h00;
    end else begin
      rdata_d = {mem_word[7] ^ poll_hit, mem_word[6:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= 8'h00;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R8
  verify_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verify_dis && sig_sel_n != 2'b00) |=> (rdata == 8'h00));

  // R9
  sig_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_sel_n == 2'b00 && addr == SIG_LO) |=> (rdata == 8'h1E));

endmodule

// File: rtl/byte_prog_ctrl.sv
module byte_prog_ctrl
  import bpc_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int WRITE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [1:0]        op,
  input  logic [1:0]        sig_sel_n,
  input  logic              hv_ok,
  input  logic              prog_strobe,
  input  logic              prog_dis,
  input  logic              verify_dis,
  output logic [7:0]        rdata,
  output logic              ready,
  output logic              err_flag,
  output logic              lock_req,
  output logic [1:0]        lock_id
);

  localparam int DEPTH = 1 << ADDR_W;

  logic              start_code, start_lock, busy, poll_hit;
  logic [7:0]        code_mem [DEPTH];
  logic [ADDR_W-1:0] last_addr_q, last_addr_d;
  logic              poll_q, poll_d;
  logic              lock_req_q;
  logic [1:0]        lock_id_q, lock_id_d;

  bpc_cmd_decode u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (prog_strobe),
    .hv_ok      (hv_ok),
    .op         (prog_op_e'(op)),
    .prog_dis   (prog_dis),
    .busy       (busy),
    .start_code (start_code),
    .start_lock (start_lock),
    .err_flag   (err_flag)
  );

  bpc_write_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_code | start_lock),
    .busy  (busy)
  );

  // byte array, written when a code command is accepted
  always_ff @(posedge clk) begin
    if (start_code) code_mem[addr] <= wdata;
  end

  always_comb begin
    last_addr_d = start_code ? addr : last_addr_q;
    poll_d      = start_code ? 1'b1 : (start_lock ? 1'b0 : poll_q);
    lock_id_d   = start_lock ? addr[1:0] : lock_id_q;
    poll_hit    = busy & poll_q & (addr == last_addr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr_q <= '0;
      poll_q      <= 1'b0;
      lock_req_q  <= 1'b0;
      lock_id_q   <= 2'b00;
    end else begin
      last_addr_q <= last_addr_d;
      poll_q      <= poll_d;
      lock_req_q  <= start_lock;
      lock_id_q   <= lock_id_d;
    end
  end

  bpc_read_path #(.ADDR_W(ADDR_W)) u_read (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .sig_sel_n  (sig_sel_n),
    .verify_dis (verify_dis),
    .poll_hit   (poll_hit),
    .mem_word   (code_mem[addr]),
    .rdata      (rdata)
  );

  assign ready    = ~busy;
  assign lock_req = lock_req_q;
  assign lock_id  = lock_id_q;

  // R2
  code_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_code |=> !ready);

  // R7
  lock_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_lock |=> (lock_req && !ready));

  // R7
  lock_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req |=> !lock_req);

endmodule

// File: tb/byte_prog_ctrl_tb_top.sv
`timescale 1ns/100ps
module byte_prog_ctrl_tb_top;

  localparam int AW = 8;
  localparam int WC = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [7:0]    wdata;
  logic [1:0]    op;
  logic [1:0]    sig_sel_n;
  logic          hv_ok, prog_strobe, prog_dis, verify_dis;
  logic [7:0]    rdata;
  logic          ready, err_flag, lock_req;
  logic [1:0]    lock_id;

  byte_prog_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .op(op),
    .sig_sel_n(sig_sel_n), .hv_ok(hv_ok), .prog_strobe(prog_strobe),
    .prog_dis(prog_dis), .verify_dis(verify_dis), .rdata(rdata),
    .ready(ready), .err_flag(err_flag), .lock_req(lock_req), .lock_id(lock_id)
  );

  always #2.5 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string cur_req = "R1";

  // behavioural reference model
  bit [7:0] m_mem [int];
  bit       m_busy, m_strq, m_err, m_poll, m_lreq, m_known;
  bit [1:0] m_lid;
  bit [7:0] m_rd;
  int       m_cnt, m_last;

  always @(posedge clk or negedge rst_n) begin
    bit rise, acc;
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_strq = 0; m_err = 0; m_poll = 0;
      m_lreq = 0; m_lid = 0; m_rd = 0; m_known = 1;
    end else begin
      if (sig_sel_n == 2'b00) begin
        m_known = 1;
        if      (addr == 8'h30) m_rd = 8'h1E;
        else if (addr == 8'h31) m_rd = 8'h87;
        else if (addr == 8'h32) m_rd = 8'h01;
        else                    m_rd = 8'h00;
      end else if (verify_dis) begin
        m_known = 1; m_rd = 8'h00;
      end else if (m_mem.exists(int'(addr))) begin
        m_known = 1; m_rd = m_mem[int'(addr)];
        if (m_busy && m_poll && int'(addr) == m_last) m_rd[7] = ~m_rd[7];
      end else begin
        m_known = 0;
      end
      rise   = prog_strobe && !m_strq;
      m_strq = prog_strobe;
      acc = rise && hv_ok && !m_busy &&
            ((op == 2'b01 && !prog_dis) || op == 2'b10);
      if (rise && !acc) m_err = 1;
      m_lreq = 0;
      if (m_busy) begin
        if (m_cnt == 0) m_busy = 0;
        else            m_cnt--;
      end
      if (acc) begin
        m_busy = 1; m_cnt = WC - 1;
        if (op == 2'b01) begin
          m_mem[int'(addr)] = wdata; m_last = int'(addr); m_poll = 1;
        end else begin
          m_poll = 0; m_lreq = 1; m_lid = addr[1:0];
        end
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("ready", int'(ready), int'(!m_busy));
      cmp("err_flag", int'(err_flag), int'(m_err));
      cmp("lock_req", int'(lock_req), int'(m_lreq));
      if (m_lreq) cmp("lock_id", int'(lock_id), int'(m_lid));
      if (m_known) cmp("rdata", int'(rdata), int'(m_rd));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
  endtask

  task automatic issue(bit [7:0] a, bit [7:0] d, bit [1:0] o);
    addr = a; wdata = d; op = o; hv_ok = 1'b1;
    tick(1); prog_strobe = 1'b1; tick(1); prog_strobe = 1'b0; tick(1);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; op = 2'b00; sig_sel_n = 2'b11;
    hv_ok = 1'b0; prog_strobe = 1'b0; prog_dis = 1'b0; verify_dis = 1'b0;
    tick(3); rst_n = 1'b1;
    cur_req = "R1"; tick(2);

    cur_req = "R9"; sig_sel_n = 2'b00;
    for (int i = 8'h2F; i <= 8'h33; i++) begin addr = 8'(i); tick(1); end
    verify_dis = 1'b1; addr = 8'h31; tick(2);
    verify_dis = 1'b0; sig_sel_n = 2'b11; tick(1);

    cur_req = "R2"; issue(8'h03, 8'h3C, 2'b01);
    cur_req = "R3"; tick(WC + 2);
    cur_req = "R4"; issue(8'h05, 8'hA5, 2'b01); addr = 8'h05; tick(4);
    cur_req = "R5"; addr = 8'h03; tick(3); addr = 8'h05; tick(WC);

    cur_req = "R6"; do_reset(); addr = 8'h09; wdata = 8'h99; op = 2'b01;
    hv_ok = 1'b0; tick(1); prog_strobe = 1'b1; tick(1); prog_strobe = 1'b0; tick(3);
    do_reset(); issue(8'h06, 8'h12, 2'b01); issue(8'h07, 8'h34, 2'b01); tick(WC);
    do_reset(); issue(8'h05, 8'h00, 2'b00); issue(8'h05, 8'h00, 2'b11); tick(2);
    do_reset(); prog_dis = 1'b1; issue(8'h05, 8'h11, 2'b01); addr = 8'h05; tick(WC);

    cur_req = "R7"; do_reset(); issue(8'h02, 8'h00, 2'b10);
    addr = 8'h05; tick(WC + 2); issue(8'h03, 8'h00, 2'b10); tick(WC + 2);
    prog_dis = 1'b0;

    cur_req = "R8"; verify_dis = 1'b1; addr = 8'h05; tick(3); verify_dis = 1'b0;

    cur_req = "R10"; addr = 8'h07; wdata = 8'h7F; op = 2'b01; hv_ok = 1'b1;
    tick(1); prog_strobe = 1'b1; tick(3 * WC); prog_strobe = 1'b0; tick(4);
    addr = 8'h03; tick(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule